// File: doc/BRIEF.md
# Serially Loaded Table Threshold Comparator

This block is one functional unit of a rule-based classifier. A pattern arrives one element per cycle, each element paired with its position number. The unit waits for the element at one chosen position. It compares that element against a stored constant and keeps a one-bit verdict in its output register. The verdict is either "greater than" or "less than or equal".

None of the chosen position, the constant or the comparison sense is held in a configuration register. All three are encoded as the contents of six 16-entry, 4-input lookup tables. Each table is a 16-bit shift register, and its stored bit is selected by a 4-bit index:

- Two tables decide whether the current position is the chosen one.
- Three tables compare the two halves of the element against the two halves of the constant.
- The last table merges the three partial results into the final verdict.

Reconfiguration shifts one bit into every table per cycle. A complete reload takes 16 cycles. During a reload the output register keeps its previous verdict. Turning a position, constant and sense into table contents is the job of software or of the surrounding system; the bench carries its own helper for this.

Top module: `lut_cmp_unit`

## Requirements
- R1: After reset `fu_out` is 0 and every table entry is 0. Until a load completes, no position matches, so `fu_out` stays 0 whatever is streamed.
- R2: Each cycle with `cfg_shift` high, every table shifts in one bit. The bit shifted in first ends at entry 15 after 16 shifts, and entry i answers index value i. The `cfg_bits` lanes are assigned as follows:
  - bit 0: upper-position table, indexed by `elem_addr[5:2]`
  - bit 1: lower-position table, indexed by `{2'b00, elem_addr[1:0]}`
  - bit 2: upper-greater table, indexed by `elem[7:4]`
  - bit 3: upper-equal table, indexed by `elem[7:4]`
  - bit 4: lower-greater table, indexed by `elem[3:0]`
  - bit 5: merge table, indexed by `{1'b0, upper-greater, upper-equal, lower-greater}`
- R3: A position matches only when both position tables return 1 for the current `elem_addr`.
- R4: With merge contents for "greater than", a matched element e loads `fu_out` with 1 exactly when e > C (unsigned 8-bit).
- R5: With merge contents for "less than or equal", a matched element loads `fu_out` with 1 exactly when e <= C.
- R6: In a cycle with no match, `fu_out` keeps its value.
- R7: While `cfg_shift` is high, `fu_out` keeps its value even if the position tables currently report a match.
- R8: The verdict for a matched element appears on `fu_out` after the next rising clock edge (one cycle of latency).
- R9: The comparison is exact at the boundaries:
  - e equal to C gives 0 for "greater than" and 1 for "less than or equal".
  - Equal upper halves are decided by the lower halves.
  - C = 255 never gives "greater than".

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_shift | input | 1 | Shift enable for all six tables |
| cfg_bits | input | 6 | One configuration bit per table per shift cycle |
| elem_addr | input | 6 | Position number of the streamed element |
| elem | input | 8 | Streamed data element |
| fu_out | output | 1 | Registered comparison verdict |

## Verification
The hardest situation to create from the ports is a reload that passes over a matching position. Halfway through the 16 shifts, the tables hold a mix of old and new contents. They may then flag a match for an arbitrary address while the output must stay frozen. The bench drives random positions and elements on every shift cycle so that such transient matches occur. It checks the held verdict on each of those cycles. Directed loads then place the matched element exactly at C, at C±1, and across nibble carries, to reach the merge-table boundaries.

// File: rtl/lut_cmp_pkg.sv
package lut_cmp_pkg;
    // Geometry of one shift-loaded table
    localparam int TBL_AW    = 4;
    localparam int TBL_DEPTH = 1 << TBL_AW;
    // Streamed data geometry (fixed by the table input count)
    localparam int ELEM_W    = 2 * TBL_AW;
    localparam int ADDR_W    = TBL_AW + 2;
    localparam int LO_AW     = ADDR_W - TBL_AW;

    // Configuration lane assignment
    typedef enum int {
        LANE_ADDR_HI = 0,
        LANE_ADDR_LO = 1,
        LANE_HI_GT   = 2,
        LANE_HI_EQ   = 3,
        LANE_LO_GT   = 4,
        LANE_MERGE   = 5
    } cfg_lane_e;

    localparam int NUM_LANES = 6;
endpackage

// File: rtl/srl_table.sv
module srl_table
    import lut_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    input  logic [TBL_AW-1:0] rd_idx,
    output logic              rd_bit
);
    logic [TBL_DEPTH-1:0] cells;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cells <= '0;
        end else if (shift_en) begin
            cells <= {cells[TBL_DEPTH-2:0], din};
        end
    end

    assign rd_bit = cells[rd_idx];
endmodule

// File: rtl/addr_match.sv
module addr_match
    import lut_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [1:0]        cfg_in,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    logic hi_ok;
    logic lo_ok;
    logic [TBL_AW-1:0] lo_idx;

    assign lo_idx = {{(TBL_AW-LO_AW){1'b0}}, addr[LO_AW-1:0]};

    srl_table u_hi (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (cfg_in[0]),
        .rd_idx  (addr[ADDR_W-1:LO_AW]),
        .rd_bit  (hi_ok)
    );

    srl_table u_lo (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (cfg_in[1]),
        .rd_idx  (lo_idx),
        .rd_bit  (lo_ok)
    );

    // Carry-chain style AND of the two halves
    assign hit = hi_ok & lo_ok;
endmodule

// File: rtl/thresh_fn.sv
module thresh_fn
    import lut_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic [3:0]        cfg_in,
    input  logic [ELEM_W-1:0] elem,
    output logic              verdict
);
    // part[0]: upper greater, part[1]: upper equal, part[2]: lower greater
    logic [2:0] part;
    logic [TBL_AW-1:0] merge_idx;

    for (genvar g = 0; g < 3; g++) begin : g_nib
        logic [TBL_AW-1:0] idx;
        if (g == 2) begin : g_lo
            assign idx = elem[TBL_AW-1:0];
        end else begin : g_hi
            assign idx = elem[ELEM_W-1:TBL_AW];
        end
        srl_table u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .shift_en(shift_en),
            .din     (cfg_in[g]),
            .rd_idx  (idx),
            .rd_bit  (part[g])
        );
    end

    assign merge_idx = {1'b0, part[0], part[1], part[2]};

    srl_table u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (cfg_in[3]),
        .rd_idx  (merge_idx),
        .rd_bit  (verdict)
    );
endmodule

// File: rtl/lut_cmp_unit.sv
module lut_cmp_unit
    import lut_cmp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_shift,
    input  logic [NUM_LANES-1:0] cfg_bits,
    input  logic [ADDR_W-1:0]    elem_addr,
    input  logic [ELEM_W-1:0]    elem,
    output logic                 fu_out
);
    logic addr_hit;
    logic fn_val;

    addr_match u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(cfg_shift),
        .cfg_in  (cfg_bits[LANE_ADDR_LO:LANE_ADDR_HI]),
        .addr    (elem_addr),
        .hit     (addr_hit)
    );

    thresh_fn u_fn (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(cfg_shift),
        .cfg_in  (cfg_bits[LANE_MERGE:LANE_HI_GT]),
        .elem    (elem),
        .verdict (fn_val)
    );

    // Result register: captures only on a match outside a reload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fu_out <= 1'b0;
        end else if (!cfg_shift && addr_hit) begin
            fu_out <= fn_val;
        end
    end
endmodule

// File: rtl/lut_cmp_chk.sv
module lut_cmp_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_shift,
    input logic addr_hit,
    input logic fn_val,
    input logic fu_out
);
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n) !$isunknown(fu_out)); // R1
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $rose(rst_n) |-> !fu_out); // R1
    AST_FREEZE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) cfg_shift |=> $stable(fu_out)); // R7
    AST_FREEZE_MISS: assert property (@(posedge clk) disable iff (!rst_n) !addr_hit |=> $stable(fu_out)); // R6
    AST_CAPTURE_NEXT: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_shift && addr_hit) |=> (fu_out == $past(fn_val))); // R8
endmodule

bind lut_cmp_unit lut_cmp_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_shift(cfg_shift),
    .addr_hit (addr_hit),
    .fn_val   (fn_val),
    .fu_out   (fu_out)
);

// File: tb/sim_lut_cmp_unit.sv
`timescale 1ns/1ps
module sim_lut_cmp_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_shift = 1'b0;
    logic [5:0] cfg_bits = '0;
    logic [5:0] elem_addr = '0;
    logic [7:0] elem = '0;
    logic       fu_out;

    int n_tests = 0;
    int n_fail  = 0;

    // Bench model of the loaded configuration
    bit         cur_valid = 0;
    logic [5:0] cur_a = '0;
    logic [7:0] cur_c = '0;
    bit         cur_lte = 0;
    logic       exp_out = 1'b0;

    always #2.5 clk = ~clk;

    lut_cmp_unit u0 (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_bits(cfg_bits),
        .elem_addr(elem_addr), .elem(elem), .fu_out(fu_out)
    );

    task automatic chk(string req, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // Table content helpers: entry i answers index value i
    function automatic logic [15:0] t_ahi(logic [5:0] a);
        for (int i = 0; i < 16; i++) t_ahi[i] = (i == int'(a[5:2]));
    endfunction
    function automatic logic [15:0] t_alo(logic [5:0] a);
        for (int i = 0; i < 16; i++) t_alo[i] = (i == int'(a[1:0]));
    endfunction
    function automatic logic [15:0] t_hgt(logic [7:0] c);
        for (int i = 0; i < 16; i++) t_hgt[i] = (i > int'(c[7:4]));
    endfunction
    function automatic logic [15:0] t_heq(logic [7:0] c);
        for (int i = 0; i < 16; i++) t_heq[i] = (i == int'(c[7:4]));
    endfunction
    function automatic logic [15:0] t_lgt(logic [7:0] c);
        for (int i = 0; i < 16; i++) t_lgt[i] = (i > int'(c[3:0]));
    endfunction
    function automatic logic [15:0] t_merge(bit lte);
        for (int i = 0; i < 16; i++) begin
            logic g, e, l;
            g = i[2]; e = i[1]; l = i[0];
            t_merge[i] = (i < 8) ? ((g | (e & l)) ^ lte) : 1'b0;
        end
    endfunction

    function automatic logic verdict(logic [7:0] e, logic [7:0] c, bit lte);
        return lte ? (e <= c) : (e > c);
    endfunction

    // One cycle: drive at negedge, check shortly after the next rising edge
    task automatic cyc(bit sh, logic [5:0] bits, logic [5:0] ad, logic [7:0] el, string req);
        @(negedge clk);
        cfg_shift = sh; cfg_bits = bits; elem_addr = ad; elem = el;
        @(posedge clk);
        #1;
        if (!sh && cur_valid && ad == cur_a) exp_out = verdict(el, cur_c, cur_lte);
        chk(req, fu_out, exp_out);
    endtask

    // Reload: last entry first so the first-shifted bit lands in entry 15
    task automatic load(logic [5:0] a, logic [7:0] c, bit lte);
        logic [15:0] v0, v1, v2, v3, v4, v5;
        v0 = t_ahi(a); v1 = t_alo(a); v2 = t_hgt(c);
        v3 = t_heq(c); v4 = t_lgt(c); v5 = t_merge(lte);
        for (int i = 15; i >= 0; i--) begin
            // R7: random positions while the tables are half loaded
            cyc(1'b1, {v5[i], v4[i], v3[i], v2[i], v1[i], v0[i]},
                6'($urandom), 8'($urandom), "R7 hold while shifting");
        end
        cur_valid = 1; cur_a = a; cur_c = c; cur_lte = lte;
    endtask

    // Stream one pattern; the matched position gets a corner or forced value
    task automatic stream(bit force_en, logic [7:0] force_el);
        for (int p = 0; p < 64; p++) begin
            logic [7:0] el;
            el = 8'($urandom);
            if (cur_valid && p == int'(cur_a)) begin
                case ($urandom % 6)
                    0: el = cur_c;
                    1: el = cur_c + 8'd1;
                    2: el = cur_c - 8'd1;
                    3: el = {cur_c[7:4], 4'($urandom)};
                    default: ;
                endcase
                if (force_en) el = force_el;
                cyc(1'b0, 6'($urandom), 6'(p), el,
                    cur_lte ? "R2 R3 R5 R8 R9 match" : "R2 R3 R4 R8 R9 match");
            end else begin
                cyc(1'b0, 6'($urandom), 6'(p), el, "R3 R6 no match");
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        #1 chk("R1 reset output", fu_out, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        // R1: cleared tables match nothing
        stream(1'b0, 8'h00);

        // Directed corners
        load(6'd63, 8'hFF, 1'b0); stream(1'b1, 8'hFF);   // R9 never greater
        load(6'd0,  8'h00, 1'b1); stream(1'b1, 8'h00);   // R9 equal gives LTE
        load(6'd5,  8'h7F, 1'b0); stream(1'b1, 8'h80);   // R4 upper decides
        load(6'd42, 8'h37, 1'b0); stream(1'b1, 8'h38);   // R9 lower decides
        load(6'd42, 8'h37, 1'b1); stream(1'b1, 8'h37);   // R5 equal
        load(6'd17, 8'h90, 1'b0); stream(1'b1, 8'h8F);   // R4 borrow across nibble

        // Constrained random configurations
        for (int k = 0; k < 40; k++) begin
            load(6'($urandom), 8'($urandom), 1'($urandom));
            stream(1'b0, 8'h00);
            stream(1'b0, 8'h00);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule